// File: doc/BRIEF.md
# Sample-LSB Frame Strobe Inserter

This block sits on a 12-bit sample stream in front of a parallel output bus. When insertion is enabled it overwrites bit 0 of each outgoing sample with a frame strobe. The strobe is 1 on the last sample of each frame and 0 on every other sample, so a receiver can find frame boundaries without a separate strobe lane. The cost is one bit of sample resolution for as long as insertion stays on.

A position counter tracks where each valid sample falls within a frame of programmable length. Insertion is active only when two conditions hold. The pattern-select field must choose the LSB-strobe pattern. The selected gate source must also be asserted. The gate source can be the external sync pin, a software bit, a forced-on setting or a forced-off setting. The gate decision is taken on the first sample of each frame and held for the rest of that frame. The same applies to a new frame length, which takes effect when the next frame starts. Because of this, a frame never carries a partial strobe pattern.

The gate is a two-state machine. State GATE_PASS leaves the data untouched and state GATE_INSERT replaces the LSB. The machine has one transition. On every valid sample at frame position 0 it moves to GATE_INSERT if the selected source is asserted, and to GATE_PASS if it is not. At every other time it stays in its current state. Reset puts it in GATE_PASS.

Top module: `lsb_strobe_inserter`

## Requirements
- R1: A synchronous reset clears out_valid and out_data to 0. It sets the frame position to 0 and the frame length to 8.
- R2: When insertion is inactive, out_data equals the input sample on all 12 bits.
- R3: When insertion is active, out_data[11:1] equals in_data[11:1]. out_data[0] is 1 on the sample at frame position length-1 and 0 at every other position. With length 8, positions 0 to 6 carry 0 and position 7 carries 1.
- R4: Insertion happens only when pat_sel equals 2. The values 0, 1 and 3 always pass the data through unchanged.
- R5: src_sel chooses the gate source. 0 selects ext_sync, 1 selects sw_sync, 2 forces the gate on and 3 forces it off.
- R6: The gate value is sampled on the valid sample at frame position 0 and held until the next frame starts. A source change in the middle of a frame has no effect on that frame.
- R7: frame_len is clamped to the range 2 to 32. A new value is loaded on the last sample of a frame and applies from the next frame. After the last position, the position returns to 0.
- R8: The frame position advances only on cycles with in_valid high. On a cycle with in_valid low, the position and out_data do not change.
- R9: out_data and out_valid are registered with one cycle of latency. out_valid equals in_valid from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 12 | Input sample |
| pat_sel | input | 2 | Pattern select; 2 selects LSB strobe |
| src_sel | input | 2 | Gate source: 0 pin, 1 software, 2 on, 3 off |
| frame_len | input | 6 | Frame length, clamped to 2..32 |
| ext_sync | input | 1 | External sync gate (synchronous to clk) |
| sw_sync | input | 1 | Software sync gate bit |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 12 | Output sample with optional strobe in bit 0 |

## Verification
The samples driven have LSB 1, LSB 0 and mixed values. This shows whether bit 0 comes from the strobe or from the sample, and whether pass-through keeps every bit. The gate sources are toggled in the middle of a frame and at frame boundaries. This separates gating that acts immediately from gating that waits for the next frame. Frame lengths of 8, 2 and 32 are tried, as are out-of-range lengths of 1 and 40, and the length is changed in the middle of a frame. This exposes errors in the wrap point, the clamping and the frame at which a new length applies. Idle gaps between valid samples show whether the counter and the output move only on valid samples.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [1:0] {
        SRC_PIN    = 2'd0,
        SRC_SOFT   = 2'd1,
        SRC_ALWAYS = 2'd2,
        SRC_NEVER  = 2'd3
    } src_sel_t;

    typedef enum logic {
        GATE_PASS   = 1'b0,
        GATE_INSERT = 1'b1
    } gate_state_t;

    localparam logic [1:0] PAT_LSB_STROBE = 2'd2;

endpackage

// File: rtl/fsp_pos_counter.sv
module fsp_pos_counter #(
    parameter int MIN_LEN = 2,
    parameter int MAX_LEN = 32,
    parameter int RST_LEN = 8,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int POS_W   = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [LEN_W-1:0] cfg_len,
    output logic [POS_W-1:0] pos,
    output logic [LEN_W-1:0] len_q,
    output logic             at_start,
    output logic             at_last
);

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] RST_L = LEN_W'(RST_LEN);

    logic [LEN_W-1:0] len_clamped;

    always_comb begin
        if (cfg_len < MIN_L)
            len_clamped = MIN_L;
        else if (cfg_len > MAX_L)
            len_clamped = MAX_L;
        else
            len_clamped = cfg_len;
    end

    assign at_start = (pos == '0);
    assign at_last  = ({{(LEN_W-POS_W){1'b0}}, pos} == (len_q - LEN_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= '0;
            len_q <= RST_L;
        end else if (adv) begin
            if (at_last) begin
                pos   <= '0;
                len_q <= len_clamped;
            end else begin
                pos   <= pos + POS_W'(1);
            end
        end
    end

endmodule

// File: rtl/fsp_gate_fsm.sv
module fsp_gate_fsm
    import fsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       at_start,
    input  logic [1:0] src_sel,
    input  logic       ext_sync,
    input  logic       sw_sync,
    output logic       gate_on
);

    gate_state_t state_q, state_d;
    logic        src_now;

    always_comb begin
        unique case (src_sel_t'(src_sel))
            SRC_PIN:    src_now = ext_sync;
            SRC_SOFT:   src_now = sw_sync;
            SRC_ALWAYS: src_now = 1'b1;
            SRC_NEVER:  src_now = 1'b0;
            default:    src_now = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_PASS:   if (adv && at_start && src_now)  state_d = GATE_INSERT;
            GATE_INSERT: if (adv && at_start && !src_now) state_d = GATE_PASS;
            default:     state_d = GATE_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= GATE_PASS;
        else
            state_q <= state_d;
    end

    always_comb begin
        if (at_start)
            gate_on = src_now;
        else
            gate_on = (state_q == GATE_INSERT);
    end

endmodule

// File: rtl/fsp_out_stage.sv
module fsp_out_stage #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              insert,
    input  logic              strobe,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [DATA_W-1:0] word;

    always_comb begin
        if (insert)
            word = {in_data[DATA_W-1:1], strobe};
        else
            word = in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= word;
        end
    end

endmodule

// File: rtl/lsb_strobe_inserter.sv
module lsb_strobe_inserter
    import fsp_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int MIN_LEN = 2,
    parameter int MAX_LEN = 32,
    parameter int RST_LEN = 8,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        pat_sel,
    input  logic [1:0]        src_sel,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              ext_sync,
    input  logic              sw_sync,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int POS_W = $clog2(MAX_LEN);

    logic [POS_W-1:0] pos;
    logic [LEN_W-1:0] len_q;
    logic             at_start;
    logic             at_last;
    logic             gate_on;
    logic             insert;

    fsp_pos_counter #(
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN),
        .RST_LEN (RST_LEN),
        .LEN_W   (LEN_W),
        .POS_W   (POS_W)
    ) u_pos (
        .clk      (clk),
        .rst      (rst),
        .adv      (in_valid),
        .cfg_len  (frame_len),
        .pos      (pos),
        .len_q    (len_q),
        .at_start (at_start),
        .at_last  (at_last)
    );

    fsp_gate_fsm u_gate (
        .clk      (clk),
        .rst      (rst),
        .adv      (in_valid),
        .at_start (at_start),
        .src_sel  (src_sel),
        .ext_sync (ext_sync),
        .sw_sync  (sw_sync),
        .gate_on  (gate_on)
    );

    assign insert = gate_on && (pat_sel == PAT_LSB_STROBE);

    fsp_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .insert    (insert),
        .strobe    (at_last),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
    parameter int DATA_W  = 12,
    parameter int MAX_LEN = 32,
    parameter int LEN_W   = 6,
    parameter int POS_W   = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [1:0]        pat_sel,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [POS_W-1:0]  pos,
    input logic [LEN_W-1:0]  len_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0 && pos == '0));

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(pos)));

    // R3
    upper_bits_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_data[DATA_W-1:1] == $past(in_data[DATA_W-1:1])));

    // R4
    no_pattern_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pat_sel != 2'd2) |=> (out_data == $past(in_data)));

    // R7
    pos_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, pos} < {1'b0, len_q}) && (len_q >= LEN_W'(2)) && (len_q <= LEN_W'(MAX_LEN)));

endmodule

bind lsb_strobe_inserter fsp_checker #(
    .DATA_W  (DATA_W),
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W),
    .POS_W   (POS_W)
) u_fsp_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .pat_sel   (pat_sel),
    .out_valid (out_valid),
    .out_data  (out_data),
    .pos       (pos),
    .len_q     (len_q)
);

// File: tb/tb_lsb_strobe_inserter.sv
`timescale 1ns/1ps
module tb_lsb_strobe_inserter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic [1:0]  pat_sel = 2'd0;
    logic [1:0]  src_sel = 2'd0;
    logic [5:0]  frame_len = 6'd8;
    logic        ext_sync = 1'b0;
    logic        sw_sync = 1'b0;
    logic        out_valid;
    logic [11:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_pos;
    int m_len;
    bit m_gate;
    bit exp_v;
    logic [11:0] exp_d;
    int seed = 7;

    always #10 clk = ~clk;

    lsb_strobe_inserter dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .pat_sel   (pat_sel),
        .src_sel   (src_sel),
        .frame_len (frame_len),
        .ext_sync  (ext_sync),
        .sw_sync   (sw_sync),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input string tag);
        checks++;
        if (out_valid !== exp_v || out_data !== exp_d) begin
            failures++;
            $display("FAIL %s: got v=%0b d=%03h expected v=%0b d=%03h",
                     tag, out_valid, out_data, exp_v, exp_d);
        end
    endtask

    function automatic int clamp_len(input int l);
        if (l < 2) return 2;
        if (l > 32) return 32;
        return l;
    endfunction

    task automatic model_reset();
        m_pos = 0; m_len = 8; m_gate = 0; exp_v = 0; exp_d = '0;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check(tag);
    endtask

    // drive one cycle, update the model, check one cycle later
    task automatic step(input bit v, input logic [11:0] d, input string tag);
        bit src_now, g, strobe;
        in_valid = v;
        in_data  = d;
        exp_v = v;
        if (v) begin
            case (src_sel)
                2'd0: src_now = ext_sync;
                2'd1: src_now = sw_sync;
                2'd2: src_now = 1'b1;
                default: src_now = 1'b0;
            endcase
            if (m_pos == 0) m_gate = src_now;
            g = m_gate;
            strobe = (m_pos == m_len - 1);
            if (g && pat_sel == 2'd2) exp_d = {d[11:1], strobe};
            else exp_d = d;
            if (strobe) begin
                m_pos = 0;
                m_len = clamp_len(int'(frame_len));
            end else begin
                m_pos++;
            end
        end
        @(negedge clk);
        check(tag);
    endtask

    function automatic logic [11:0] next_word();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return 12'(seed >> 8);
    endfunction

    initial begin
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1");

        // R4 pattern select other than 2: pass through, gate forced on
        src_sel = 2'd2;
        pat_sel = 2'd0;
        for (int i = 0; i < 10; i++) step(1'b1, next_word() | 12'h001, "R4");
        pat_sel = 2'd1;
        for (int i = 0; i < 10; i++) step(1'b1, next_word(), "R4");
        pat_sel = 2'd3;
        for (int i = 0; i < 4; i++) step(1'b1, next_word() | 12'h001, "R4");

        // R3 active insertion, frame of 8, LSB=1 data shows the strobe zeros
        do_reset("R1");
        pat_sel = 2'd2;
        src_sel = 2'd2;
        for (int i = 0; i < 24; i++) step(1'b1, 12'hFFF, "R3");
        for (int i = 0; i < 16; i++) step(1'b1, 12'hA50, "R3");

        // R5 forced off: all bits pass (R2)
        do_reset("R1");
        src_sel = 2'd3;
        for (int i = 0; i < 16; i++) step(1'b1, next_word(), "R2");

        // R5 / R6 external pin, toggled mid-frame
        do_reset("R1");
        src_sel = 2'd0;
        ext_sync = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b1, 12'hFFF, "R5");
        ext_sync = 1'b0;
        for (int i = 0; i < 5; i++) step(1'b1, 12'hFFF, "R6");
        for (int i = 0; i < 8; i++) step(1'b1, 12'hFFF, "R6");
        ext_sync = 1'b1;
        for (int i = 0; i < 8; i++) step(1'b1, 12'hFFF, "R6");

        // R5 software bit
        src_sel = 2'd1;
        sw_sync = 1'b1;
        for (int i = 0; i < 8; i++) step(1'b1, 12'h3FF, "R5");
        sw_sync = 1'b0;
        for (int i = 0; i < 8; i++) step(1'b1, 12'h3FF, "R5");

        // R7 length changes: 2, 32, clamp 1 -> 2, clamp 40 -> 32
        src_sel = 2'd2;
        frame_len = 6'd2;
        for (int i = 0; i < 3; i++) step(1'b1, 12'h001, "R7");
        frame_len = 6'd32;
        for (int i = 0; i < 40; i++) step(1'b1, 12'h001, "R7");
        frame_len = 6'd1;
        for (int i = 0; i < 40; i++) step(1'b1, 12'h001, "R7");
        frame_len = 6'd40;
        for (int i = 0; i < 70; i++) step(1'b1, 12'h001, "R7");

        // R8 idle gaps between valid samples
        frame_len = 6'd8;
        for (int i = 0; i < 40; i++) begin
            step(1'b1, next_word(), "R8");
            step(1'b0, next_word(), "R8");
            if (i % 3 == 0) step(1'b0, 12'hFFF, "R9");
        end

        // R1 reset in mid-frame, then confirm positions restart at 0 (R3)
        for (int i = 0; i < 3; i++) step(1'b1, 12'hFFF, "R3");
        do_reset("R1");
        for (int i = 0; i < 8; i++) step(1'b1, 12'hFFF, "R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule